// File: doc/BRIEF.md
# Five-Port Micro-Op Dispatch Scheduler

This block sits beside a reservation-station pool of micro-ops. Every cycle it looks at the pool entries and picks up to five of them, one for each of five execution ports. Each entry reports whether it holds a micro-op, whether that micro-op's operands are ready, its operation class and its age. Port 0 feeds the full integer unit, which does shifts, multiplies, divides and address arithmetic, and it also feeds the floating-point unit. Port 1 feeds a simple integer unit. Ports 2, 3 and 4 take loads, store addresses and store data.

Grants are combinational from the current pool and the per-port busy inputs. A granted entry is marked as issued at the next clock edge and is not offered again until the pool drops its valid bit. On each port the oldest eligible entry wins. Port 0 runs in one of four named modes each cycle. In BLOCKED mode the port is busy and nothing is granted. In MAIN mode it grants the oldest complex-integer or floating-point micro-op. In SPILL mode it grants a second simple-integer micro-op, younger than the one on port 1. In IDLE mode nothing is eligible. The mode is re-evaluated every cycle with no carried state, so no transitions exist between modes.

Top module: `dispatch_sched`

## Requirements
- R1: Each port grants at most one entry per cycle, and no entry is granted on two ports in the same cycle.
- R2: Class codes route as follows: 0 simple integer (add, subtract, branch target) to port 1, or to port 0 under R5. 1 complex integer (shift, multiply, divide, address arithmetic) to port 0. 2 floating point to port 0. 3 load to port 2. 4 store address to port 3. 5 store data to port 4. Codes 6 and 7 are never granted.
- R3: Port 0 grants at most one micro-op, taken from complex-integer and floating-point entries together, before any simple entry.
- R4: Among the entries eligible for a port, the grant goes to the smallest age value. When ages are equal, the lower entry index wins.
- R5: A simple entry goes to port 0 only when port 1 has granted an older simple entry and port 0 has no eligible complex or floating-point entry. The spilled entry is the oldest remaining simple entry.
- R6: Only entries that are both valid and ready can be granted.
- R7: A granted entry is not granted again while its valid bit stays high. Once valid has been low for a cycle, the entry can be granted afresh.
- R8: A high busy bit for a port blocks every grant on that port in that cycle. When port 1 is busy, no simple entry spills to port 0.
- R9: While reset is asserted, no grant is made, and after reset no entry counts as issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rs_valid | input | N | Entry holds a micro-op |
| rs_ready | input | N | Entry operands ready |
| rs_class | input | 3*N | Per-entry class code, entry i at bits [3i+2:3i] |
| rs_age | input | AGE_W*N | Per-entry age, smaller is older, entry i at bits [AGE_W*i +: AGE_W] |
| port_busy | input | 5 | Per-port busy, bit p for port p |
| gnt_valid | output | 5 | Port p grants this cycle |
| gnt_idx | output | 5*IDX_W | Granted entry index for port p at bits [IDX_W*p +: IDX_W] |

## Verification
Two functions meet on port 0 in the same cycle: the grant of its own complex-integer or floating-point work, and the spill of a second simple micro-op that was first offered to port 1. The bench provokes this by loading several simple entries at once, with and without complex or floating-point entries, and sometimes with port 1 busy. It then checks that a spill appears only when port 1 took an older simple entry and port 0 has nothing of its own. A random phase recycles entries and busy bits so that spill, issue exclusion and age ordering all land on the same cycle, and the behavioural model judges every port on every clock.

// File: rtl/sched_pkg.sv
package sched_pkg;

    localparam int NUM_PORTS = 5;
    localparam int CLS_W     = 3;

    localparam int PORT_MAIN  = 0;
    localparam int PORT_SIMPL = 1;
    localparam int PORT_LOAD  = 2;
    localparam int PORT_STA   = 3;
    localparam int PORT_STD   = 4;

    typedef enum logic [CLS_W-1:0] {
        OPC_ALU_SIMPLE  = 3'd0,
        OPC_ALU_COMPLEX = 3'd1,
        OPC_FLOAT       = 3'd2,
        OPC_LOAD        = 3'd3,
        OPC_ST_ADDR     = 3'd4,
        OPC_ST_DATA     = 3'd5,
        OPC_RSV6        = 3'd6,
        OPC_RSV7        = 3'd7
    } op_class_e;

    typedef enum logic [1:0] {
        P0_BLOCKED = 2'd0,
        P0_IDLE    = 2'd1,
        P0_MAIN    = 2'd2,
        P0_SPILL   = 2'd3
    } p0_mode_e;

endpackage

// File: rtl/class_router.sv
module class_router
    import sched_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N*CLS_W-1:0]             cls_flat,
    output logic [NUM_PORTS-1:0][N-1:0]    elig
);

    for (genvar i = 0; i < N; i++) begin : g_entry
        op_class_e cls;
        assign cls = op_class_e'(cls_flat[i*CLS_W +: CLS_W]);

        always_comb begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                elig[p][i] = 1'b0;
            end
            unique case (cls)
                OPC_ALU_SIMPLE:  elig[PORT_SIMPL][i] = 1'b1;
                OPC_ALU_COMPLEX: elig[PORT_MAIN][i]  = 1'b1;
                OPC_FLOAT:       elig[PORT_MAIN][i]  = 1'b1;
                OPC_LOAD:        elig[PORT_LOAD][i]  = 1'b1;
                OPC_ST_ADDR:     elig[PORT_STA][i]   = 1'b1;
                OPC_ST_DATA:     elig[PORT_STD][i]   = 1'b1;
                OPC_RSV6:        ;
                OPC_RSV7:        ;
            endcase
        end
    end

endmodule

// File: rtl/oldest_pick.sv
module oldest_pick #(
    parameter int N     = 8,
    parameter int AGE_W = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]       mask,
    input  logic [N*AGE_W-1:0] ages,
    output logic               found,
    output logic [IDX_W-1:0]   idx
);

    logic [AGE_W-1:0] best_age;

    always_comb begin
        found    = 1'b0;
        idx      = '0;
        best_age = '0;
        for (int i = 0; i < N; i++) begin
            if (mask[i] && (!found || (ages[i*AGE_W +: AGE_W] < best_age))) begin
                found    = 1'b1;
                idx      = IDX_W'(i);
                best_age = ages[i*AGE_W +: AGE_W];
            end
        end
    end

endmodule

// File: rtl/issue_tracker.sv
module issue_tracker #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] rs_valid,
    input  logic [N-1:0] grant_mask,
    output logic [N-1:0] issued
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            issued <= '0;
        end else begin
            issued <= rs_valid & (issued | grant_mask);
        end
    end

endmodule

// File: rtl/dispatch_sched.sv
module dispatch_sched
    import sched_pkg::*;
#(
    parameter int N     = 8,
    parameter int AGE_W = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N-1:0]               rs_valid,
    input  logic [N-1:0]               rs_ready,
    input  logic [N*CLS_W-1:0]         rs_class,
    input  logic [N*AGE_W-1:0]         rs_age,
    input  logic [NUM_PORTS-1:0]       port_busy,
    output logic [NUM_PORTS-1:0]       gnt_valid,
    output logic [NUM_PORTS*IDX_W-1:0] gnt_idx
);

    localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

    logic [NUM_PORTS-1:0][N-1:0] elig;
    logic [N-1:0]                issued;
    logic [N-1:0]                cand;
    logic [N-1:0]                grant_mask;

    logic [NUM_PORTS-1:0]        pick_found;
    logic [IDX_W-1:0]            pick_idx [NUM_PORTS];

    logic                        spill_found;
    logic [IDX_W-1:0]            spill_idx;
    logic [N-1:0]                spill_mask;
    logic                        p1_grant;

    p0_mode_e                    p0_mode;
    logic                        p0_valid;
    logic [IDX_W-1:0]            p0_idx;

    // Per-entry port eligibility from the class code
    class_router #(.N(N)) u_router (
        .cls_flat (rs_class),
        .elig     (elig)
    );

    // Entries that may be offered this cycle
    assign cand = rst_n ? (rs_valid & rs_ready & ~issued) : '0;

    // One oldest-first picker per port
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_pick
        oldest_pick #(.N(N), .AGE_W(AGE_W)) u_pick (
            .mask  (cand & elig[p]),
            .ages  (rs_age),
            .found (pick_found[p]),
            .idx   (pick_idx[p])
        );
    end

    assign p1_grant = pick_found[PORT_SIMPL] & ~port_busy[PORT_SIMPL];

    // Second simple candidate, excluding the one port 1 takes
    assign spill_mask = cand & elig[PORT_SIMPL] &
                        ~(p1_grant ? (ONE << pick_idx[PORT_SIMPL]) : '0);

    oldest_pick #(.N(N), .AGE_W(AGE_W)) u_spill (
        .mask  (spill_mask),
        .ages  (rs_age),
        .found (spill_found),
        .idx   (spill_idx)
    );

    // Port 0 mode decision
    always_comb begin
        if (port_busy[PORT_MAIN]) begin
            p0_mode = P0_BLOCKED;
        end else if (pick_found[PORT_MAIN]) begin
            p0_mode = P0_MAIN;
        end else if (p1_grant && spill_found) begin
            p0_mode = P0_SPILL;
        end else begin
            p0_mode = P0_IDLE;
        end
    end

    // Port 0 output per mode
    always_comb begin
        unique case (p0_mode)
            P0_BLOCKED: begin p0_valid = 1'b0; p0_idx = '0;                  end
            P0_IDLE:    begin p0_valid = 1'b0; p0_idx = '0;                  end
            P0_MAIN:    begin p0_valid = 1'b1; p0_idx = pick_idx[PORT_MAIN]; end
            P0_SPILL:   begin p0_valid = 1'b1; p0_idx = spill_idx;           end
        endcase
    end

    // Grant outputs
    always_comb begin
        gnt_valid = '0;
        gnt_idx   = '0;
        gnt_valid[PORT_MAIN]                 = p0_valid;
        gnt_idx[PORT_MAIN*IDX_W +: IDX_W]    = p0_idx;
        for (int p = 1; p < NUM_PORTS; p++) begin
            gnt_valid[p]               = pick_found[p] & ~port_busy[p];
            gnt_idx[p*IDX_W +: IDX_W]  = gnt_valid[p] ? pick_idx[p] : '0;
        end
    end

    always_comb begin
        grant_mask = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (gnt_valid[p]) begin
                grant_mask = grant_mask | (ONE << gnt_idx[p*IDX_W +: IDX_W]);
            end
        end
    end

    issue_tracker #(.N(N)) u_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .rs_valid   (rs_valid),
        .grant_mask (grant_mask),
        .issued     (issued)
    );

endmodule

// File: rtl/dispatch_sched_checker.sv
module dispatch_sched_checker
    import sched_pkg::*;
#(
    parameter int N     = 8,
    parameter int AGE_W = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [N-1:0]               rs_valid,
    input logic [N-1:0]               rs_ready,
    input logic [N*CLS_W-1:0]         rs_class,
    input logic [N*AGE_W-1:0]         rs_age,
    input logic [NUM_PORTS-1:0]       port_busy,
    input logic [NUM_PORTS-1:0]       gnt_valid,
    input logic [NUM_PORTS*IDX_W-1:0] gnt_idx
);

    localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

    logic [IDX_W-1:0] g_i   [NUM_PORTS];
    logic [CLS_W-1:0] g_cls [NUM_PORTS];
    logic [AGE_W-1:0] g_age [NUM_PORTS];
    logic [N-1:0]     seen;
    logic [N-1:0]     gmask;

    always_comb begin
        gmask = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            g_i[p]   = gnt_idx[p*IDX_W +: IDX_W];
            g_cls[p] = rs_class[g_i[p]*CLS_W +: CLS_W];
            g_age[p] = rs_age[g_i[p]*AGE_W +: AGE_W];
            if (gnt_valid[p]) gmask = gmask | (ONE << g_i[p]);
        end
    end

    // Entries seen granted since their valid last rose
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen <= '0;
        else        seen <= rs_valid & (seen | gmask);
    end

    assert_reset_quiet_R9: assert property (@(posedge clk)
        !rst_n |-> gnt_valid == '0);

    assert_spill_rule_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid[PORT_MAIN] && g_cls[PORT_MAIN] == CLS_W'(OPC_ALU_SIMPLE)) |->
        (gnt_valid[PORT_SIMPL] &&
         ((g_age[PORT_SIMPL] < g_age[PORT_MAIN]) ||
          (g_age[PORT_SIMPL] == g_age[PORT_MAIN] && g_i[PORT_SIMPL] < g_i[PORT_MAIN]))));

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
            port_busy[p] |-> !gnt_valid[p]);

        assert_ready_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
            gnt_valid[p] |-> (rs_valid[g_i[p]] && rs_ready[g_i[p]]));

        assert_no_regrant_R7: assert property (@(posedge clk) disable iff (!rst_n)
            gnt_valid[p] |-> !seen[g_i[p]]);

        if (p == PORT_MAIN) begin : g_main
            assert_route_R2: assert property (@(posedge clk) disable iff (!rst_n)
                gnt_valid[p] |-> (g_cls[p] <= CLS_W'(OPC_FLOAT)));
        end else if (p == PORT_SIMPL) begin : g_simpl
            assert_route_R2: assert property (@(posedge clk) disable iff (!rst_n)
                gnt_valid[p] |-> (g_cls[p] == CLS_W'(OPC_ALU_SIMPLE)));
        end else begin : g_mem
            assert_route_R2: assert property (@(posedge clk) disable iff (!rst_n)
                gnt_valid[p] |-> (g_cls[p] == CLS_W'(p + 1)));
        end

        for (genvar q = p + 1; q < NUM_PORTS; q++) begin : g_pair
            assert_distinct_R1: assert property (@(posedge clk) disable iff (!rst_n)
                (gnt_valid[p] && gnt_valid[q]) |-> (g_i[p] != g_i[q]));
        end
    end

endmodule

bind dispatch_sched dispatch_sched_checker #(.N(N), .AGE_W(AGE_W)) u_checker (.*);

// File: tb/test_dispatch_sched.sv
module test_dispatch_sched;

    localparam int N     = 8;
    localparam int AGE_W = 4;
    localparam int IDX_W = 3;
    localparam int NP    = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      rs_valid;
    logic [N-1:0]      rs_ready;
    logic [N*3-1:0]    rs_class;
    logic [N*AGE_W-1:0] rs_age;
    logic [NP-1:0]     port_busy;
    logic [NP-1:0]     gnt_valid;
    logic [NP*IDX_W-1:0] gnt_idx;

    int b_valid [N];
    int b_ready [N];
    int b_cls   [N];
    int b_age   [N];
    int b_busy  [NP];
    int m_issued [N];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    dispatch_sched #(.N(N), .AGE_W(AGE_W)) i_dispatch_sched (
        .clk(clk), .rst_n(rst_n), .rs_valid(rs_valid), .rs_ready(rs_ready),
        .rs_class(rs_class), .rs_age(rs_age), .port_busy(port_busy),
        .gnt_valid(gnt_valid), .gnt_idx(gnt_idx)
    );

    task automatic drive();
        for (int i = 0; i < N; i++) begin
            rs_valid[i] = (b_valid[i] != 0);
            rs_ready[i] = (b_ready[i] != 0);
            rs_class[i*3 +: 3] = 3'(b_cls[i]);
            rs_age[i*AGE_W +: AGE_W] = AGE_W'(b_age[i]);
        end
        for (int p = 0; p < NP; p++) port_busy[p] = (b_busy[p] != 0);
    endtask

    function automatic bit fits(int i, int p);
        case (p)
            0: return b_cls[i] == 1 || b_cls[i] == 2;
            1: return b_cls[i] == 0;
            default: return b_cls[i] == p + 1;
        endcase
    endfunction

    function automatic int oldest(int p, int excl);
        int best = -1;
        for (int i = 0; i < N; i++) begin
            if (i != excl && b_valid[i] != 0 && b_ready[i] != 0 && m_issued[i] == 0 && fits(i, p)) begin
                if (best < 0 || b_age[i] < b_age[best]) best = i;
            end
        end
        return best;
    endfunction

    // Drive, compare mid-cycle, advance the model at the edge
    task automatic tick(string tag);
        int e [NP];
        drive();
        #5;
        for (int p = 0; p < NP; p++) e[p] = -1;
        if (rst_n) begin
            e[1] = b_busy[1] != 0 ? -1 : oldest(1, -1);
            if (b_busy[0] == 0) begin
                e[0] = oldest(0, -1);
                if (e[0] < 0 && e[1] >= 0) e[0] = oldest(1, e[1]);
            end
            for (int p = 2; p < NP; p++) e[p] = b_busy[p] != 0 ? -1 : oldest(p, -1);
        end
        for (int p = 0; p < NP; p++) begin
            int act;
            act = gnt_valid[p] ? int'(gnt_idx[p*IDX_W +: IDX_W]) : -1;
            checks++;
            if (act != e[p]) begin
                fails++;
                $display("FAIL %s port%0d actual=%0d expected=%0d at %0t", tag, p, act, e[p], $time);
            end
        end
        @(posedge clk);
        for (int i = 0; i < N; i++) begin
            if (!rst_n || b_valid[i] == 0) m_issued[i] = 0;
        end
        if (rst_n) for (int p = 0; p < NP; p++) if (e[p] >= 0) m_issued[e[p]] = 1;
        @(negedge clk);
    endtask

    task automatic clear_all();
        for (int i = 0; i < N; i++) begin
            b_valid[i] = 0; b_ready[i] = 1; b_cls[i] = 7; b_age[i] = 15;
        end
        for (int p = 0; p < NP; p++) b_busy[p] = 0;
    endtask

    task automatic put(int i, int cls, int age);
        b_valid[i] = 1; b_ready[i] = 1; b_cls[i] = cls; b_age[i] = age;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) m_issued[i] = 0;
        clear_all();
        @(negedge clk);
        // R9: pool full of work under reset, nothing granted
        for (int i = 0; i < N; i++) put(i, i % 6, i);
        tick("R9"); tick("R9");
        rst_n = 1'b1;
        clear_all(); tick("R9");

        // R2: one entry of each class code including reserved ones
        for (int i = 0; i < N; i++) put(i, i, 8 - i);
        tick("R2");
        clear_all(); tick("R2");

        // R4: loads with ages 5,2,2 then follow-on picks under R7
        put(0, 3, 5); put(3, 3, 2); put(6, 3, 2);
        tick("R4"); tick("R4"); tick("R7"); tick("R7");
        clear_all(); tick("R4");

        // R3: floating point older than complex, two simples
        put(1, 1, 4); put(2, 2, 3); put(0, 0, 1); put(5, 0, 2);
        tick("R3"); tick("R3"); tick("R3");
        clear_all(); tick("R3");

        // R5: three simples, no main-class work
        put(0, 0, 1); put(1, 0, 2); put(2, 0, 3);
        tick("R5"); tick("R5"); tick("R5");
        clear_all(); tick("R5");

        // R8: port 1 busy stops spill; port 0 busy stops floating point
        put(0, 0, 1); put(1, 0, 2); b_busy[1] = 1;
        tick("R8"); b_busy[1] = 0; tick("R8");
        clear_all(); put(4, 2, 0); put(5, 3, 1); b_busy[0] = 1; b_busy[2] = 1;
        tick("R8"); b_busy[0] = 0; b_busy[2] = 0; tick("R8");
        clear_all(); tick("R8");

        // R6: entries not ready are skipped until ready rises
        put(0, 3, 0); b_ready[0] = 0; put(1, 3, 9);
        tick("R6"); b_ready[0] = 1; tick("R6");
        clear_all(); tick("R6");

        // R7: valid held high blocks regrant; dropped and re-raised regrants
        put(2, 5, 3); tick("R7"); tick("R7");
        b_valid[2] = 0; tick("R7"); b_valid[2] = 1; tick("R7");
        clear_all(); tick("R7");

        // R1: all five ports in one cycle, then random traffic
        put(0, 2, 1); put(1, 0, 2); put(2, 3, 3); put(3, 4, 4); put(4, 5, 5);
        tick("R1");
        clear_all(); tick("R1");
        for (int c = 0; c < 600; c++) begin
            for (int i = 0; i < N; i++) begin
                if (b_valid[i] == 0) begin
                    if ($urandom_range(1, 0) == 1) begin
                        b_valid[i] = 1; b_cls[i] = $urandom_range(7, 0);
                        b_age[i] = $urandom_range(15, 0);
                        b_ready[i] = $urandom_range(1, 0);
                    end
                end else if (m_issued[i] != 0 && $urandom_range(1, 0) == 1) begin
                    b_valid[i] = 0;
                end else if ($urandom_range(3, 0) == 0) begin
                    b_ready[i] = 1 - b_ready[i];
                end
            end
            for (int p = 0; p < NP; p++) b_busy[p] = ($urandom_range(3, 0) == 0) ? 1 : 0;
            tick("R1");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule